// File: doc/BRIEF.md
# Flash Sector Address Mapper

This block turns a 24-bit CPU address into the index of an on-chip flash sector and an offset inside that sector. The result depends on the access kind (instruction fetch, data read or data write), a remap control bit and a bootstrap-mode input. The block also flags the hidden test sector, hits on the flash control-register window, whether that window may be used, and an alias of the two highest sectors as a notional second bank.

While a program or erase operation is busy, flash read data is replaced by a fixed trap opcode. The busy flag is registered, so the replacement starts on the cycle after the busy input first rises. The address decode itself is purely combinational.

Top module: `flash_sector_map`

## Requirements
- R1: Segment-0 mapping (fetch or read with remap=0): addresses 0x000000–0x007FFF hit sectors 0..3 (8 KB each, index = addr[14:13], offset = addr[12:0]), and 0x008000–0x017FFF miss (hit=0).
- R2: Segment-1 mapping (acc=2 write, or remap=1): sectors 0..3 decode at 0x010000–0x017FFF with the same index and offset fields, and 0x000000–0x00FFFF misses; in bootstrap mode writes use this mapping whatever remap holds, and reads follow remap.
- R3: In both mappings 0x018000–0x01FFFF hits sector 4 with offset = addr[14:0], and each 64 KB segment 0x02..0x08 (addr[23:16]) hits sector addr[23:16]+3 with offset = addr[15:0].
- R4: With boot=1 and acc=0 (fetch), 0x000000–0x000FFF hits the test sector (index 12, test=1, offset = addr[11:0]); any other fetch in bootstrap mode misses; test=0 whenever boot=0 or acc is not a fetch.
- R5: Addresses above 0x08FFFF and every address not listed above give hit=0.
- R6: Addresses 0x0E0000–0x0EFFFF set regwin=1 (with hit=0); reg_ok=1 only when regwin=1 and reg_en=1.
- R7: When hit=1 on sector 10 or 11, bank1_hit=1 and bank1_sec is 0 or 1 respectively; otherwise bank1_hit=0.
- R8: rdata equals arr_rdata unless the op_busy value captured at the last clock edge is 1, hit=1 and acc is a fetch or read; then rdata = 0x009B. Writes never see the substitution.
- R9: The busy capture register clears in reset; op_busy held high through reset does not substitute data in the first cycle after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 24 | CPU byte address |
| acc | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| remap | input | 1 | Moves sectors 0..3 to segment 1 |
| boot | input | 1 | Bootstrap mode |
| reg_en | input | 1 | Control-register window enable |
| op_busy | input | 1 | Program/erase in progress |
| arr_rdata | input | 16 | Data from flash array |
| hit | output | 1 | Address maps to a flash sector |
| sector | output | 4 | Sector index (12 = test sector) |
| offset | output | 16 | Byte offset in sector |
| test | output | 1 | Test sector selected |
| regwin | output | 1 | Address in control-register window |
| reg_ok | output | 1 | Control-register window usable |
| bank1_hit | output | 1 | Sector 10/11 seen as second-bank sector |
| bank1_sec | output | 1 | Second-bank sector index |
| rdata | output | 16 | Read data after busy override |

## Verification
The hardest situation to reach is the interplay of bootstrap mode, remap and access kind at the segment-0/segment-1 edges, since a single address flips between hit and miss depending on all three. Random stimulus picks addresses from a list of sector boundaries plus small signed offsets, with every combination of access kind, remap and boot, and a bench model predicts each result. The one-cycle delay of the busy override is exercised by raising op_busy and sampling both before and after the next edge, including with op_busy held through reset.

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter logic [DW-1:0] TRAP = 16'h009B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    acc,
  input  logic          remap,
  input  logic          boot,
  input  logic          reg_en,
  input  logic          op_busy,
  input  logic [DW-1:0] arr_rdata,
  output logic          hit,
  output logic [3:0]    sector,
  output logic [15:0]   offset,
  output logic          test,
  output logic          regwin,
  output logic          reg_ok,
  output logic          bank1_hit,
  output logic          bank1_sec,
  output logic [DW-1:0] rdata
);
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd2;

  logic       seg1, is_fetch, boot_fetch;
  logic [7:0] seg;
  logic       busy_q;

  assign seg        = addr[23:16];
  assign is_fetch   = (acc == ACC_FETCH);
  assign seg1       = (acc == ACC_WRITE) || remap;
  assign boot_fetch = boot && is_fetch;

  always_comb begin
    hit    = 1'b0;
    sector = 4'd0;
    offset = 16'd0;
    test   = 1'b0;
    if (boot_fetch) begin
      if (addr[23:12] == 12'h000) begin
        hit = 1'b1; test = 1'b1; sector = 4'd12; offset = {4'd0, addr[11:0]};
      end
    end else if (addr[23:15] == (seg1 ? 9'h002 : 9'h000)) begin
      hit = 1'b1; sector = {2'b00, addr[14:13]}; offset = {3'd0, addr[12:0]};
    end else if (addr[23:15] == 9'h003) begin
      hit = 1'b1; sector = 4'd4; offset = {1'b0, addr[14:0]};
    end else if (seg >= 8'h02 && seg <= 8'h08) begin
      hit = 1'b1; sector = seg[3:0] + 4'd3; offset = addr[15:0];
    end
  end

  assign regwin    = (seg == 8'h0E);
  assign reg_ok    = regwin && reg_en;
  assign bank1_hit = hit && (sector == 4'd10 || sector == 4'd11);
  assign bank1_sec = bank1_hit && (sector == 4'd11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= op_busy;

  assign rdata = (busy_q && hit && acc != ACC_WRITE) ? TRAP : arr_rdata;

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  a_r1_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sector < 4'd4) |-> offset < 16'h2000);
  a_r4_test_only_boot_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    test |-> (boot && acc == ACC_FETCH && offset < 16'h1000));
  a_r5_high_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[23:16] > 8'h08) |-> !hit);
  a_r6_window_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    regwin |-> (!hit && (reg_ok == reg_en)));
  a_r7_alias_range: assert property (@(posedge clk) disable iff (!rst_n)
    bank1_hit |-> (addr[23:16] == 8'h07 || addr[23:16] == 8'h08));
  a_r8_trap_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_busy) && hit && acc != ACC_WRITE) |-> rdata == TRAP);
  a_r8_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_WRITE) |-> rdata == arr_rdata);
endmodule

// File: tb/flash_sector_map_test.sv
module flash_sector_map_test;
  logic clk = 0, rst_n = 0;
  logic [23:0] addr = 0;
  logic [1:0] acc = 0;
  logic remap = 0, boot = 0, reg_en = 0, op_busy = 0;
  logic [15:0] arr_rdata = 16'h1234;
  logic hit, test, regwin, reg_ok, bank1_hit, bank1_sec;
  logic [3:0] sector;
  logic [15:0] offset, rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_sector_map uut (.clk, .rst_n, .addr, .acc, .remap, .boot, .reg_en,
    .op_busy, .arr_rdata, .hit, .sector, .offset, .test, .regwin, .reg_ok,
    .bank1_hit, .bank1_sec, .rdata);

  // expected {hit, test, sector, offset}
  function automatic logic [21:0] model(int a, int k, bit rm, bit bt);
    bit s1 = (k == 2) || rm;
    if (bt && k == 0) begin
      if (a < 'h1000) return {1'b1, 1'b1, 4'd12, 16'(a)};
      return 22'd0;
    end
    if (!s1 && a < 'h8000) return {2'b10, 4'(a / 'h2000), 16'(a % 'h2000)};
    if (s1 && a >= 'h10000 && a < 'h18000)
      return {2'b10, 4'((a - 'h10000) / 'h2000), 16'(a % 'h2000)};
    if (a >= 'h18000 && a < 'h20000) return {2'b10, 4'd4, 16'(a - 'h18000)};
    if (a >= 'h20000 && a < 'h90000) return {2'b10, 4'(a / 'h10000 + 3), 16'(a % 'h10000)};
    return 22'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h acc=%0d rm=%0b bt=%0b actual=%h expected=%h",
               req, addr, acc, remap, boot, act, exp);
    end
  endtask

  task automatic check_all(bit busy_cap);
    logic [21:0] e = model(int'(addr), int'(acc), remap, boot);
    bit ew = (addr[23:16] == 8'h0E);
    chk(boot && acc == 0 ? "R4 hit" : (addr < 24'h18000 ? "R1/R2 hit" :
        (addr < 24'h90000 ? "R3 hit" : "R5 hit")), hit, e[21]);
    if (e[21]) begin
      chk("R1/R2/R3 sector", sector, e[19:16]);
      chk("R1/R2/R3 offset", offset, e[15:0]);
    end
    chk("R4 test", test, e[20]);
    chk("R6 regwin", regwin, ew);
    chk("R6 reg_ok", reg_ok, ew && reg_en);
    chk("R7 bank1_hit", bank1_hit, e[21] && (e[19:16] == 10 || e[19:16] == 11));
    if (e[21] && (e[19:16] == 10 || e[19:16] == 11))
      chk("R7 bank1_sec", bank1_sec, e[19:16] == 11);
    chk("R8 rdata", rdata, (busy_cap && e[21] && acc != 2) ? 16'h009B : arr_rdata);
  endtask

  task automatic step(logic [23:0] a, logic [1:0] k, bit rm, bit bt, bit bz);
    @(negedge clk);
    addr = a; acc = k; remap = rm; boot = bt; op_busy = bz;
    reg_en = $urandom % 2; arr_rdata = 16'($urandom);
    @(posedge clk); #1;
    check_all(bz);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int bnd[12] = '{'h0, 'h2000, 'h8000, 'h10000, 'h18000, 'h20000,
                 'h70000, 'h80000, 'h90000, 'hE0000, 'hF0000, 'h1000};

  initial begin
    void'($urandom(32'd4711));
    // R9: busy held through reset
    op_busy = 1; addr = 24'h020010; acc = 1; arr_rdata = 16'hBEEF;
    repeat (3) @(posedge clk);
    #1; chk("R9 reset rdata", rdata, 16'hBEEF);
    @(negedge clk); rst_n = 1;
    #1; chk("R9 first cycle after reset", rdata, 16'hBEEF);
    @(posedge clk); #1;
    chk("R8 trap after edge", rdata, 16'h009B);
    // R8 timing: busy rises, no trap until the next edge
    @(negedge clk); op_busy = 0;
    @(posedge clk); #1;
    @(negedge clk); op_busy = 1; #1;
    chk("R8 before edge", rdata, 16'hBEEF);
    @(posedge clk); #1;
    chk("R8 after edge", rdata, 16'h009B);
    // directed corners
    step(24'h007FFF, 0, 0, 0, 0);
    step(24'h008000, 1, 0, 0, 0);
    step(24'h000000, 2, 0, 1, 0);
    step(24'h010000, 2, 0, 1, 0);
    step(24'h000FFF, 0, 0, 1, 0);
    step(24'h001000, 0, 0, 1, 0);
    step(24'h016000, 1, 1, 1, 1);
    step(24'h08FFFF, 1, 0, 0, 1);
    step(24'h0E0004, 1, 0, 0, 0);
    step(24'h070000, 2, 0, 0, 1);
    // random sweep around boundaries
    for (int i = 0; i < 4000; i++) begin
      int b = bnd[$urandom % 12];
      int d = int'($urandom % 64) - 32;
      logic [23:0] a = ($urandom % 4 == 0) ? 24'($urandom) : 24'(b + d);
      logic [1:0] k = 2'($urandom % 3);
      step(a, k, $urandom % 2, $urandom % 2, $urandom % 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule